// File: doc/BRIEF.md
# Dual-Channel DAC Serial Register Port

This block is the digital front end of a two-channel digital-to-analog converter. A host sends 24-bit command frames over a three-wire serial port: an active-low frame select, a serial clock and a data input. The block decodes each frame into a write or a read of a small register map and presents each channel's converter code as a parallel word. The map has an input register and an output (converter) register for each channel, plus a configuration bit. A separate active-low load strobe decides when input registers move into the output registers. An active-low clear input forces the output registers to a defined code.

All serial pins, the load strobe and the clear input are asynchronous to the system clock. Each one passes through a two-flop synchroniser, and the serial clock and frame select are also edge-detected in the system clock domain. The port has no handshake and no back-pressure. The host must keep each serial-clock half period, and each gap around a frame-select edge, at least four system clocks long. The converter codes are plain level outputs. `frame_done` and `frame_error` are single-cycle status strobes.

Frame layout, MSB first: bit 23 read flag (1 = read), bit 22 reserved (must be 0), bits 21:19 register select, bits 18:16 address, bits 15:0 data.

Top module: `dual_dac_serial_if`

## Requirements
- R1: A frame is captured MSB first. One bit is taken from `sdin` on each falling edge of `sclk` while `sync_n` is low, and the frame ends when `sync_n` rises.
- R2: A frame that received any count other than 24 falling `sclk` edges is discarded. It raises `frame_error` for one cycle and changes no register.
- R3: A frame whose bit 22 is 1 is rejected in the same way as in R2.
- R4: A write with register select 000 stores the data in the input register of channel 0 (address 000), channel 1 (address 001), or both channels (address 100). Other addresses, and register selects other than 000 and 011, change no state.
- R5: If `ldac_n` is low when a write frame ends, the written channel's output register takes the data together with the input register. If `ldac_n` is high, only the input register changes.
- R6: A falling edge on `ldac_n` copies every input register into its output register.
- R7: A read frame (bit 23 = 1) selects a source, and the next frame shifts the source out on `sdo` MSB first as {8 zero bits, 16 data bits}. The first bit is present when that frame starts, and each later bit follows a rising `sclk` edge. With select 000 and address 000/001 the source is that channel's input register. With select 011 and address 001 the source is the clear-select bit in data bit 0. Any other read returns zero. After a frame that was not a valid read, `sdo` shifts out zeros.
- R8: A write with select 011 and address 001 sets the clear-select bit from data bit 0. Address 000 under select 011 is a no-operation and changes nothing.
- R9: While `clr_n` is low, both output registers hold the clear code: 0x0000 if clear-select is 0, 0x8000 if it is 1. The input registers are not changed.
- R10: After reset all registers are zero, `sdo` is 0, and neither status strobe is high.
- R11: Each accepted frame gives exactly one single-cycle `frame_done` pulse, and the register map already shows that frame's effect in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, idles high |
| sdin | input | 1 | Serial data in |
| ldac_n | input | 1 | Active-low output-register load strobe |
| clr_n | input | 1 | Active-low clear of the output registers |
| sdo | output | 1 | Serial readback data |
| dac_codes | output | 32 | Output register codes, channel 0 in bits 15:0 |
| frame_done | output | 1 | One-cycle pulse per accepted frame |
| frame_error | output | 1 | One-cycle pulse per rejected frame |

## Verification
Directed frames cover the two outcomes of a single-channel write: held in the input register with the strobe high, and passed straight to the output with the strobe low. Read-back then confirms that a value stored but not yet loaded sits in the input register. A broadcast address, an unused address and an unused register select show that the channel decode writes only where it should. Frames of 23 and 25 bits and a frame with the reserved bit set show that rejection leaves the map untouched. Seeded random frames then mix reads, writes, configuration, strobe edges and clears against a reference model, which catches ordering faults between the load strobe, the clear input and frame completion.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int FRAME_W = 24;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 3;
  localparam int PAD_W   = FRAME_W - DATA_W;

  localparam logic [2:0] SEL_DAC  = 3'b000;
  localparam logic [2:0] SEL_CTRL = 3'b011;
  localparam logic [ADDR_W-1:0] ADDR_ALL = 3'b100;
  localparam logic [ADDR_W-1:0] CTRL_CFG = 3'b001;

  typedef struct packed {
    logic              rd;
    logic              rsv;
    logic [2:0]        sel;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
  parameter int           W   = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [1:0] st;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= {2{RST[g]}};
      else        st <= {st[0], d_i[g]};
    end
    assign lvl_o[g] = st[1];
  end
endmodule

// File: rtl/dacif_frame.sv
module dacif_frame
  import dacif_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sync_lvl,
  input  logic   sync_fall,
  input  logic   sync_rise,
  input  logic   sclk_fall,
  input  logic   sdin_lvl,
  output logic   frm_valid,
  output logic   frm_error,
  output frame_t frm_word,
  output logic   in_frame
);
  localparam int CW = $clog2(FRAME_W + 2);
  localparam logic [CW-1:0] CNT_SAT  = CW'(FRAME_W + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(FRAME_W);

  logic [FRAME_W-1:0] shreg;
  logic [CW-1:0]      cnt;
  logic               active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg     <= '0;
      cnt       <= '0;
      active    <= 1'b0;
      frm_valid <= 1'b0;
      frm_error <= 1'b0;
    end else begin
      frm_valid <= 1'b0;
      frm_error <= 1'b0;
      if (sync_fall) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (active && sclk_fall && !sync_lvl) begin
        shreg <= {shreg[FRAME_W-2:0], sdin_lvl};
        if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      end else if (active && sync_rise) begin
        active <= 1'b0;
        if (cnt == CNT_FULL && !shreg[FRAME_W-2]) frm_valid <= 1'b1;
        else                                      frm_error <= 1'b1;
      end
    end
  end

  assign frm_word = frame_t'(shreg);
  assign in_frame = active;
endmodule

// File: rtl/dacif_regs.sv
module dacif_regs
  import dacif_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  frm_valid,
  input  logic                  frm_error,
  input  frame_t                frm_word,
  input  logic                  ldac_n_lvl,
  input  logic                  ldac_fall,
  input  logic                  clr_act,
  input  logic                  sclk_rise,
  input  logic                  in_frame,
  output logic [NCH*DATA_W-1:0] dac_flat,
  output logic [NCH*DATA_W-1:0] inp_flat,
  output logic                  clr_sel,
  output logic                  sdo,
  output logic                  frame_done,
  output logic                  frame_error
);
  localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

  logic               cmd_ok, wr_dac, wr_cfg;
  logic [DATA_W-1:0]  clr_code, rdata;
  logic [FRAME_W-1:0] tx_q;

  assign cmd_ok   = frm_valid && !frm_word.rsv;
  assign wr_dac   = cmd_ok && !frm_word.rd && frm_word.sel == SEL_DAC;
  assign wr_cfg   = cmd_ok && !frm_word.rd && frm_word.sel == SEL_CTRL
                    && frm_word.addr == CTRL_CFG;
  assign clr_code = clr_sel ? MID_CODE : '0;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic              hit;
    logic [DATA_W-1:0] inp_r, dac_r;
    assign hit = wr_dac && (frm_word.addr == ADDR_W'(c) || frm_word.addr == ADDR_ALL);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        inp_r <= '0;
        dac_r <= '0;
      end else begin
        if (hit) inp_r <= frm_word.data;
        if (clr_act)                 dac_r <= clr_code;
        else if (ldac_fall)          dac_r <= hit ? frm_word.data : inp_r;
        else if (hit && !ldac_n_lvl) dac_r <= frm_word.data;
      end
    end
    assign inp_flat[c*DATA_W +: DATA_W] = inp_r;
    assign dac_flat[c*DATA_W +: DATA_W] = dac_r;
  end

  always_comb begin
    rdata = '0;
    if (frm_word.sel == SEL_DAC) begin
      for (int c = 0; c < NCH; c++) begin
        if (frm_word.addr == ADDR_W'(c)) rdata = inp_flat[c*DATA_W +: DATA_W];
      end
    end
    if (frm_word.sel == SEL_CTRL && frm_word.addr == CTRL_CFG)
      rdata = {{(DATA_W-1){1'b0}}, clr_sel};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_sel     <= 1'b0;
      tx_q        <= '0;
      frame_done  <= 1'b0;
      frame_error <= 1'b0;
    end else begin
      frame_done  <= cmd_ok;
      frame_error <= frm_error;
      if (wr_cfg) clr_sel <= frm_word.data[0];
      if (cmd_ok)                     tx_q <= frm_word.rd ? {{PAD_W{1'b0}}, rdata} : '0;
      else if (frm_error)             tx_q <= '0;
      else if (in_frame && sclk_rise) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
    end
  end

  assign sdo = tx_q[FRAME_W-1];
endmodule

// File: rtl/dual_dac_serial_if.sv
module dual_dac_serial_if
  import dacif_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DW  = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_n,
  input  logic              sclk,
  input  logic              sdin,
  input  logic              ldac_n,
  input  logic              clr_n,
  output logic              sdo,
  output logic [NCH*DW-1:0] dac_codes,
  output logic              frame_done,
  output logic              frame_error
);
  localparam int NIN = 5;

  logic [NIN-1:0] raw, lvl;
  logic [2:0]     prev_q;
  logic           sync_fall, sync_rise, sclk_fall, sclk_rise, ldac_fall, clr_act;
  logic           frm_valid, frm_error, in_frame, clr_sel;
  frame_t         frm_word;
  logic [NCH*DW-1:0] inp_flat;

  assign raw = {clr_n, ldac_n, sdin, sclk, sync_n};

  dacif_sync #(.W(NIN), .RST(5'b11011)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .lvl_o(lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 3'b111;
    else        prev_q <= {lvl[3], lvl[1], lvl[0]};
  end

  assign sync_fall = !lvl[0] &&  prev_q[0];
  assign sync_rise =  lvl[0] && !prev_q[0];
  assign sclk_fall = !lvl[1] &&  prev_q[1];
  assign sclk_rise =  lvl[1] && !prev_q[1];
  assign ldac_fall = !lvl[3] &&  prev_q[2];
  assign clr_act   = !lvl[4];

  dacif_frame u_frame (
    .clk(clk), .rst_n(rst_n), .sync_lvl(lvl[0]), .sync_fall(sync_fall),
    .sync_rise(sync_rise), .sclk_fall(sclk_fall), .sdin_lvl(lvl[2]),
    .frm_valid(frm_valid), .frm_error(frm_error), .frm_word(frm_word),
    .in_frame(in_frame)
  );

  dacif_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_error(frm_error),
    .frm_word(frm_word), .ldac_n_lvl(lvl[3]), .ldac_fall(ldac_fall),
    .clr_act(clr_act), .sclk_rise(sclk_rise), .in_frame(in_frame),
    .dac_flat(dac_codes), .inp_flat(inp_flat), .clr_sel(clr_sel), .sdo(sdo),
    .frame_done(frame_done), .frame_error(frame_error)
  );
endmodule

// File: rtl/dacif_check.sv
module dacif_check #(
  parameter int NCH = 2,
  parameter int DW  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_done,
  input logic              frame_error,
  input logic              clr_act,
  input logic              clr_sel,
  input logic [NCH*DW-1:0] dac_flat,
  input logic [NCH*DW-1:0] inp_flat
);
  localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] ZRO = '0;

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  a_r2_done_or_error: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && frame_error));

  a_r2_error_keeps_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    frame_error |-> $stable(inp_flat));

  a_r4_inputs_move_only_on_frames: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |-> $stable(inp_flat));

  a_r9_clear_code: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> dac_flat == {NCH{($past(clr_sel) ? MID : ZRO)}});
endmodule

bind dual_dac_serial_if dacif_check #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_error(frame_error),
  .clr_act(clr_act), .clr_sel(clr_sel), .dac_flat(dac_codes), .inp_flat(inp_flat)
);

// File: tb/dual_dac_serial_if_test.sv
module dual_dac_serial_if_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_n = 1'b1, sclk = 1'b1, sdin = 1'b0, ldac_n = 1'b1, clr_n = 1'b1;
  logic sdo, frame_done, frame_error;
  logic [31:0] dac_codes;

  int checks = 0, errors = 0;
  int seen_done = 0, seen_err = 0;

  logic [15:0] m_inp [2];
  logic [15:0] m_dac [2];
  logic        m_sel = 1'b0, m_ldac = 1'b1, m_clr = 1'b1;
  int          m_done = 0, m_err = 0;
  logic [23:0] m_tx = '0;

  always #10 clk = ~clk;

  dual_dac_serial_if uut (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .sdin(sdin),
    .ldac_n(ldac_n), .clr_n(clr_n), .sdo(sdo), .dac_codes(dac_codes),
    .frame_done(frame_done), .frame_error(frame_error)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_done)  seen_done++;
      if (frame_error) seen_err++;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [23:0] mk(input bit rd, input bit rsv, input logic [2:0] sel,
                                     input logic [2:0] addr, input logic [15:0] data);
    return {rd, rsv, sel, addr, data};
  endfunction

  function automatic void m_settle();
    if (!m_clr) for (int c = 0; c < 2; c++) m_dac[c] = m_sel ? 16'h8000 : 16'h0000;
  endfunction

  function automatic void m_frame(input logic [23:0] w, input int nb);
    logic [15:0] rdat;
    if (nb != 24 || w[22]) begin
      m_err++;
      m_tx = '0;
      return;
    end
    m_done++;
    if (w[23]) begin
      rdat = '0;
      if (w[21:19] == 3'b000 && w[18:16] < 3'd2) rdat = m_inp[w[16]];
      if (w[21:19] == 3'b011 && w[18:16] == 3'b001) rdat = {15'b0, m_sel};
      m_tx = {8'h00, rdat};
    end else begin
      m_tx = '0;
      if (w[21:19] == 3'b000) begin
        for (int c = 0; c < 2; c++) begin
          if (w[18:16] == 3'(c) || w[18:16] == 3'b100) begin
            m_inp[c] = w[15:0];
            if (!m_ldac) m_dac[c] = w[15:0];
          end
        end
      end
      if (w[21:19] == 3'b011 && w[18:16] == 3'b001) m_sel = w[0];
    end
    m_settle();
  endfunction

  task automatic check_state(input string tag);
    chk(dac_codes == {m_dac[1], m_dac[0]}, tag, "dac codes", dac_codes, {m_dac[1], m_dac[0]});
    chk(seen_done == m_done, tag, "done pulses", seen_done, m_done);
    chk(seen_err == m_err, tag, "error pulses", seen_err, m_err);
  endtask

  task automatic do_frame(input logic [23:0] w, input int nb, input string tag);
    logic [23:0] rx, exp_rx;
    exp_rx = m_tx;
    m_frame(w, nb);
    rx = '0;
    sync_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      sdin = (i < 24) ? w[23-i] : 1'b0;
      repeat (4) @(negedge clk);
      rx = {rx[22:0], sdo};
      sclk = 1'b0;
      repeat (8) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    sync_n = 1'b1;
    repeat (14) @(negedge clk);
    if (nb == 24) chk(rx == exp_rx, "R7", "sdo readback", {8'h0, rx}, {8'h0, exp_rx});
    check_state(tag);
  endtask

  task automatic set_ldac(input logic v, input string tag);
    if (m_ldac && !v && m_clr) begin
      m_dac[0] = m_inp[0];
      m_dac[1] = m_inp[1];
    end
    m_ldac = v;
    ldac_n = v;
    repeat (10) @(negedge clk);
    check_state(tag);
  endtask

  task automatic set_clr(input logic v, input string tag);
    m_clr = v;
    clr_n = v;
    m_settle();
    repeat (10) @(negedge clk);
    check_state(tag);
  endtask

  initial begin
    int unsigned seed;
    logic [2:0]  sel, addr;
    int          nb;
    seed = $urandom(32'd4242);
    m_inp[0] = '0; m_inp[1] = '0; m_dac[0] = '0; m_dac[1] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R10 reset state
    chk(dac_codes == 32'h0, "R10", "dac after reset", dac_codes, 32'h0);
    chk(sdo == 1'b0, "R10", "sdo after reset", {31'h0, sdo}, 32'h0);
    chk(!frame_done && !frame_error, "R10", "strobes after reset",
        {30'h0, frame_done, frame_error}, 32'h0);

    // R5 held write, R1 bit order, R7 readback of input register
    do_frame(mk(0, 0, 3'b000, 3'b000, 16'hA5C3), 24, "R5");
    do_frame(mk(1, 0, 3'b000, 3'b000, 16'h0000), 24, "R1");
    do_frame(mk(0, 0, 3'b011, 3'b000, 16'h0000), 24, "R7");
    // R6 strobe falling edge loads
    set_ldac(1'b0, "R6");
    // R5 pass-through write
    do_frame(mk(0, 0, 3'b000, 3'b001, 16'h1234), 24, "R5");
    // R4 broadcast, unused address, unused select
    do_frame(mk(0, 0, 3'b000, 3'b100, 16'h0F0F), 24, "R4");
    do_frame(mk(0, 0, 3'b000, 3'b101, 16'hFFFF), 24, "R4");
    do_frame(mk(0, 0, 3'b010, 3'b000, 16'hEEEE), 24, "R4");
    // R2 short and long frames, R3 reserved bit
    do_frame(mk(0, 0, 3'b000, 3'b000, 16'h5555), 23, "R2");
    do_frame(mk(0, 0, 3'b000, 3'b000, 16'h5555), 25, "R2");
    do_frame(mk(0, 1, 3'b000, 3'b000, 16'h7777), 24, "R3");
    // R8 clear-select write and no-op, R9 clear
    do_frame(mk(0, 0, 3'b011, 3'b001, 16'h0001), 24, "R8");
    do_frame(mk(0, 0, 3'b011, 3'b000, 16'h0000), 24, "R8");
    do_frame(mk(1, 0, 3'b011, 3'b001, 16'h0000), 24, "R8");
    set_clr(1'b0, "R9");
    do_frame(mk(1, 0, 3'b000, 3'b001, 16'h0000), 24, "R9");
    set_clr(1'b1, "R9");
    do_frame(mk(0, 0, 3'b011, 3'b000, 16'h0000), 24, "R11");

    for (int k = 0; k < 90; k++) begin
      case ($urandom % 8)
        0, 1, 2, 3: sel = 3'b000;
        4, 5:       sel = 3'b011;
        default:    sel = 3'($urandom);
      endcase
      addr = (sel == 3'b000) ? 3'($urandom % 6) : 3'($urandom % 3);
      nb = ($urandom % 10 == 0) ? (($urandom % 2 == 0) ? 23 : 25) : 24;
      if ($urandom % 4 == 0) set_ldac(~m_ldac, "R6");
      if ($urandom % 15 == 0) begin
        set_clr(1'b0, "R9");
        set_clr(1'b1, "R9");
      end
      do_frame(mk(($urandom % 5) == 0, ($urandom % 12) == 0, sel, addr, 16'($urandom)),
               nb, "R4");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule